// File: doc/BRIEF.md
# Loop-Body Micro-Op Issue Queue

This block sits between a loop-streaming front end and the rename/allocate stage of an out-of-order core. Decoded micro-ops arrive one per cycle on a valid/ready write port, each tagged with a small loop-iteration number, a laminated flag and the count of register inputs its parent instruction reads. Every cycle the block offers an issue group of up to four micro-ops to the allocator, oldest first. The allocator takes the whole group by raising `out_ready`; when it holds `out_ready` low the offered group stays in place and nothing leaves the queue.

A mode pin picks between two issue policies. With `restrict_mode` high, an issue group never spans two loop iterations, so a 10-micro-op body drains as 4, 4, 2. In this mode a laminated micro-op with more than two register inputs is unlaminated and uses two consecutive issue slots. If only one slot is left in the group, the first half goes out now and the second half opens the next group. With `restrict_mode` low, groups fill freely across iteration boundaries and nothing is split. The front end is assumed never to mispredict, so the queue has no flush or rollback path.

Back-pressure rules: a write is taken on a rising edge only when `in_valid` and `in_ready` are both high, and `in_ready` is low exactly when the queue holds `DEPTH` entries. The offered group is taken on a rising edge only when `out_ready` is high and `out_vld[0]` is high. Both conditions may hold on the same edge.

Top module: `uop_issue_queue`

## Requirements
- R1: At most four slots are valid per cycle. Valid slots are packed from slot 0 upward with no gaps, and carry micro-ops in arrival order.
- R2: With `restrict_mode`=1, every valid slot carries the same iteration tag as slot 0, and the group ends at the first micro-op whose tag differs.
- R3: With `restrict_mode`=0, a group takes four slots whenever at least four micro-ops are queued, whatever their tags, and no micro-op is split.
- R4: With `restrict_mode`=1, a micro-op with `in_lam`=1 and `in_nreg`>2 fills two adjacent slots with the same payload; the first has `out_second`=0 and the second has `out_second`=1. Any other micro-op fills one slot with `out_second`=0.
- R5: If a split micro-op arrives when only slot 3 is free, its first half issues in slot 3. Its second half issues in slot 0 of the next accepted group with `out_second`=1, and later micro-ops follow it.
- R6: While `out_ready`=0, no micro-op is consumed and the group in slot 0 stays unchanged.
- R7: `in_ready` is 0 when `DEPTH` micro-ops are held. A write offered while `in_ready`=0 is dropped and never appears at the outputs.
- R8: After reset and whenever the queue is empty, `out_vld` is all zero; after reset `in_ready` is 1.
- R9: With `restrict_mode`=1, two back-to-back 10-micro-op iterations of single-slot micro-ops issue as groups of 4, 4, 2 for each iteration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restrict_mode | input | 1 | 1: cut groups at iteration boundaries and split wide laminated micro-ops |
| in_valid | input | 1 | Write request from the front end |
| in_ready | output | 1 | Queue can accept a write (not full) |
| in_payload | input | PAY_W | Micro-op payload |
| in_iter | input | ITER_W | Loop-iteration tag |
| in_lam | input | 1 | Micro-op is laminated |
| in_nreg | input | NREG_W | Register inputs of the parent instruction |
| out_ready | input | 1 | Allocator accepts the offered group |
| out_vld | output | ISSUE_W | Per-slot valid, packed from slot 0 |
| out_payload | output | ISSUE_W*PAY_W | Slot k payload at bits [k*PAY_W +: PAY_W] |
| out_iter | output | ISSUE_W*ITER_W | Slot k iteration tag at bits [k*ITER_W +: ITER_W] |
| out_second | output | ISSUE_W | Slot carries the second half of a split micro-op |

## Verification
The outputs are decoded from queue state without a register, so a write accepted on one rising edge shows on the slots just after that edge. A group accepted on an edge is replaced by the next group just after that same edge. The bench drives inputs on the falling edge and reads the slots a little after it, so each reading reflects exactly the edges already passed. For the stall check, the same group is read again after several edges with `out_ready` low. The full-queue check reads `in_ready` once the last write has been accepted. A dropped write is checked by draining the queue and finding `out_vld` all zero.

// File: rtl/uopq_pkg.sv
package uopq_pkg;
  parameter int PAY_W  = 8;
  parameter int ITER_W = 2;
  parameter int NREG_W = 3;

  typedef struct packed {
    logic [PAY_W-1:0]  pay;
    logic [ITER_W-1:0] iter;
    logic              lam;
    logic [NREG_W-1:0] nreg;
  } uop_t;
endpackage

// File: rtl/uopq_ring.sv
module uopq_ring
  import uopq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int ISSUE_W = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(ISSUE_W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  uop_t          push_data,
  input  logic [PW-1:0] pop_n,
  output uop_t          peek   [ISSUE_W],
  output logic [ISSUE_W-1:0] ent_ok,
  output logic          full
);
  uop_t          mem [DEPTH];
  logic [AW-1:0] head, tail;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] adv(logic [AW-1:0] p, int n);
    int s;
    s = int'(p) + n;
    if (s >= DEPTH) s = s - DEPTH;
    return AW'(s);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[tail] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= adv(tail, 1);
      head  <= adv(head, int'(pop_n));
      count <= count + CW'(push) - CW'(pop_n);
    end
  end

  assign full = (count == CW'(DEPTH));

  for (genvar k = 0; k < ISSUE_W; k++) begin : g_peek
    assign peek[k]   = mem[adv(head, k)];
    assign ent_ok[k] = (count > CW'(k));
  end
endmodule

// File: rtl/uopq_grouper.sv
module uopq_grouper
  import uopq_pkg::*;
#(
  parameter int ISSUE_W     = 4,
  parameter int SPLIT_LIMIT = 2,
  localparam int PW = $clog2(ISSUE_W + 1)
) (
  input  logic               restrict_mode,
  input  logic               half_pend,
  input  uop_t               peek      [ISSUE_W],
  input  logic [ISSUE_W-1:0] ent_ok,
  output logic [ISSUE_W-1:0] slot_vld,
  output logic [PAY_W-1:0]   slot_pay  [ISSUE_W],
  output logic [ITER_W-1:0]  slot_iter [ISSUE_W],
  output logic [ISSUE_W-1:0] slot_tail,
  output logic [PW-1:0]      pop_n,
  output logic               carry
);
  always_comb begin
    int   slot;
    int   npop;
    int   need;
    logic stop;
    logic splt;
    logic resume;
    slot_vld  = '0;
    slot_tail = '0;
    carry     = 1'b0;
    slot      = 0;
    npop      = 0;
    stop      = 1'b0;
    for (int k = 0; k < ISSUE_W; k++) begin
      slot_pay[k]  = '0;
      slot_iter[k] = '0;
    end
    for (int k = 0; k < ISSUE_W; k++) begin
      splt   = 1'b0;
      resume = 1'b0;
      need   = 1;
      if (!stop && ent_ok[k]) begin
        if (restrict_mode && (peek[k].iter != peek[0].iter)) begin
          stop = 1'b1;
        end else begin
          splt   = restrict_mode && peek[k].lam &&
                   (int'(peek[k].nreg) > SPLIT_LIMIT);
          resume = (k == 0) && half_pend;
          need   = (splt && !resume) ? 2 : 1;
          if (slot + need <= ISSUE_W) begin
            slot_vld[slot]  = 1'b1;
            slot_pay[slot]  = peek[k].pay;
            slot_iter[slot] = peek[k].iter;
            slot_tail[slot] = resume;
            slot            = slot + 1;
            if (need == 2) begin
              slot_vld[slot]  = 1'b1;
              slot_pay[slot]  = peek[k].pay;
              slot_iter[slot] = peek[k].iter;
              slot_tail[slot] = 1'b1;
              slot            = slot + 1;
            end
            npop = npop + 1;
          end else if ((slot < ISSUE_W) && splt && !resume) begin
            slot_vld[slot]  = 1'b1;
            slot_pay[slot]  = peek[k].pay;
            slot_iter[slot] = peek[k].iter;
            slot            = slot + 1;
            carry           = 1'b1;
            stop            = 1'b1;
          end else begin
            stop = 1'b1;
          end
        end
      end
    end
    pop_n = PW'(npop);
  end
endmodule

// File: rtl/uop_issue_queue.sv
module uop_issue_queue
  import uopq_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int ISSUE_W     = 4,
  parameter int SPLIT_LIMIT = 2,
  localparam int PW = $clog2(ISSUE_W + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      restrict_mode,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [PAY_W-1:0]          in_payload,
  input  logic [ITER_W-1:0]         in_iter,
  input  logic                      in_lam,
  input  logic [NREG_W-1:0]         in_nreg,
  input  logic                      out_ready,
  output logic [ISSUE_W-1:0]        out_vld,
  output logic [ISSUE_W*PAY_W-1:0]  out_payload,
  output logic [ISSUE_W*ITER_W-1:0] out_iter,
  output logic [ISSUE_W-1:0]        out_second
);
  uop_t               wr_uop;
  uop_t               peek      [ISSUE_W];
  logic [ISSUE_W-1:0] ent_ok;
  logic               full;
  logic               push;
  logic               fire;
  logic               half_pend;
  logic               carry;
  logic [PW-1:0]      grp_pop;
  logic [PW-1:0]      pop_n;
  logic [PAY_W-1:0]   slot_pay  [ISSUE_W];
  logic [ITER_W-1:0]  slot_iter [ISSUE_W];

  assign wr_uop   = '{pay: in_payload, iter: in_iter, lam: in_lam, nreg: in_nreg};
  assign in_ready = !full;
  assign push     = in_valid && !full;
  assign fire     = out_ready && out_vld[0];
  assign pop_n    = fire ? grp_pop : '0;

  uopq_ring #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (wr_uop),
    .pop_n     (pop_n),
    .peek      (peek),
    .ent_ok    (ent_ok),
    .full      (full)
  );

  uopq_grouper #(.ISSUE_W(ISSUE_W), .SPLIT_LIMIT(SPLIT_LIMIT)) u_grp (
    .restrict_mode (restrict_mode),
    .half_pend     (half_pend),
    .peek          (peek),
    .ent_ok        (ent_ok),
    .slot_vld      (out_vld),
    .slot_pay      (slot_pay),
    .slot_iter     (slot_iter),
    .slot_tail     (out_second),
    .pop_n         (grp_pop),
    .carry         (carry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    half_pend <= 1'b0;
    else if (fire) half_pend <= carry;
  end

  for (genvar k = 0; k < ISSUE_W; k++) begin : g_flat
    assign out_payload[k*PAY_W +: PAY_W]   = slot_pay[k];
    assign out_iter[k*ITER_W +: ITER_W]    = slot_iter[k];
  end
endmodule

// File: rtl/uopq_checker.sv
module uopq_checker #(
  parameter int ISSUE_W = 4,
  parameter int PAY_W   = 8,
  parameter int ITER_W  = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      restrict_mode,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic                      out_ready,
  input logic [ISSUE_W-1:0]        out_vld,
  input logic [ISSUE_W*PAY_W-1:0]  out_payload,
  input logic [ISSUE_W*ITER_W-1:0] out_iter,
  input logic [ISSUE_W-1:0]        out_second
);
  assert_packed_slots_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((ISSUE_W'(out_vld + 1'b1) & out_vld) == '0));

  assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ready && out_vld[0]) |=> (out_vld[0] && $stable(out_payload[PAY_W-1:0])
                                    && $stable(out_second[0])));

  assert_full_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !(out_ready && out_vld[0])) |=> !in_ready);

  assert_empty_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_vld[0] && !(in_valid && in_ready)) |=> !out_vld[0]);

  for (genvar j = 1; j < ISSUE_W; j++) begin : g_slot
    assert_one_iter_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (restrict_mode && out_vld[j]) |->
        (out_iter[j*ITER_W +: ITER_W] == out_iter[ITER_W-1:0]));

    assert_split_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld[j] && out_second[j]) |->
        (!out_second[j-1] &&
         out_payload[j*PAY_W +: PAY_W] == out_payload[(j-1)*PAY_W +: PAY_W]));
  end
endmodule

bind uop_issue_queue uopq_checker #(
  .ISSUE_W (ISSUE_W),
  .PAY_W   (uopq_pkg::PAY_W),
  .ITER_W  (uopq_pkg::ITER_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .restrict_mode (restrict_mode),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .out_ready     (out_ready),
  .out_vld       (out_vld),
  .out_payload   (out_payload),
  .out_iter      (out_iter),
  .out_second    (out_second)
);

// File: tb/tb_uop_issue_queue.sv
`timescale 1ns/1ps
module tb_uop_issue_queue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        restrict_mode = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_payload = '0;
  logic [1:0]  in_iter = '0;
  logic        in_lam = 1'b0;
  logic [2:0]  in_nreg = '0;
  logic        out_ready = 1'b0;
  logic [3:0]  out_vld;
  logic [31:0] out_payload;
  logic [7:0]  out_iter;
  logic [3:0]  out_second;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  uop_issue_queue dut (
    .clk(clk), .rst_n(rst_n), .restrict_mode(restrict_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_payload(in_payload),
    .in_iter(in_iter), .in_lam(in_lam), .in_nreg(in_nreg),
    .out_ready(out_ready), .out_vld(out_vld), .out_payload(out_payload),
    .out_iter(out_iter), .out_second(out_second)
  );

  task automatic push(input logic [7:0] p, input logic [1:0] it,
                      input logic lam, input logic [2:0] nr);
    @(negedge clk);
    in_valid = 1'b1; in_payload = p; in_iter = it; in_lam = lam; in_nreg = nr;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Reads the offered group just after a falling edge; optionally accepts it.
  task automatic look(input string req, input int n, input logic [31:0] pay,
                      input logic [3:0] sec, input bit take);
    logic [3:0]  ev;
    logic [31:0] ap;
    logic [3:0]  as;
    @(negedge clk);
    #1;
    ev = 4'((1 << n) - 1);
    ap = '0; as = '0;
    for (int k = 0; k < 4; k++) begin
      if (out_vld[k]) begin
        ap[k*8 +: 8] = out_payload[k*8 +: 8];
        as[k] = out_second[k];
      end
    end
    checks++;
    if (out_vld !== ev || ap !== pay || as !== sec) begin
      failures++;
      $display("FAIL %s: vld=%b pay=%h sec=%b expected vld=%b pay=%h sec=%b",
               req, out_vld, ap, as, ev, pay, sec);
    end
    if (take) begin
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
  endtask

  task automatic expect_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    expect_bit("R8 reset in_ready", in_ready, 1'b1);
    expect_bit("R8 reset out_vld[0]", out_vld[0], 1'b0);
  endtask

  // R9, R2, R6, R7: restricted drain of a 10-uop iteration then part of the next.
  task automatic t_restricted_body;
    restrict_mode = 1'b1;
    for (int i = 0; i < 10; i++) push(8'(i), 2'd0, 1'b0, 3'd1);
    for (int i = 0; i < 6; i++)  push(8'(8'h10 + i), 2'd1, 1'b0, 3'd1);
    #1;
    expect_bit("R7 full in_ready", in_ready, 1'b0);
    push(8'hEE, 2'd1, 1'b0, 3'd0);       // dropped write
    look("R6 stall first read", 4, 32'h03020100, 4'b0000, 1'b0);
    repeat (3) @(negedge clk);
    look("R6 stall held group", 4, 32'h03020100, 4'b0000, 1'b1);
    look("R9 second group", 4, 32'h07060504, 4'b0000, 1'b1);
    look("R9 R2 tail group cut at iteration", 2, 32'h00000908, 4'b0000, 1'b1);
    look("R9 next iteration group", 4, 32'h13121110, 4'b0000, 1'b1);
    look("R2 R7 last group no dropped entry", 2, 32'h00001514, 4'b0000, 1'b1);
    look("R7 R8 empty after drain", 0, 32'h0, 4'b0000, 1'b0);
  endtask

  // R3: unrestricted groups span iterations and never split.
  task automatic t_unrestricted;
    restrict_mode = 1'b0;
    for (int i = 0; i < 6; i++)
      push(8'(8'h20 + i), 2'd2, (i == 2), (i == 2) ? 3'd3 : 3'd1);
    for (int i = 0; i < 6; i++) push(8'(8'h30 + i), 2'd3, 1'b0, 3'd2);
    look("R3 group 1 no split", 4, 32'h23222120, 4'b0000, 1'b1);
    look("R3 group spans iterations", 4, 32'h31302524, 4'b0000, 1'b1);
    look("R3 R1 group 3", 4, 32'h35343332, 4'b0000, 1'b1);
    look("R8 empty", 0, 32'h0, 4'b0000, 1'b0);
  endtask

  // R4: restricted splitting by register-input count.
  task automatic t_split;
    restrict_mode = 1'b1;
    push(8'h40, 2'd0, 1'b1, 3'd3);
    push(8'h41, 2'd0, 1'b1, 3'd2);
    push(8'h42, 2'd0, 1'b0, 3'd4);
    push(8'h43, 2'd0, 1'b1, 3'd3);
    look("R4 split uses two slots", 4, 32'h42414040, 4'b0010, 1'b1);
    look("R4 split whole in next group", 2, 32'h00004343, 4'b0010, 1'b1);
    look("R8 empty", 0, 32'h0, 4'b0000, 1'b0);
  endtask

  // R5 with R2: split half carried into next cycle, then iteration cut.
  task automatic t_carry;
    restrict_mode = 1'b1;
    push(8'h50, 2'd1, 1'b0, 3'd1);
    push(8'h51, 2'd1, 1'b0, 3'd1);
    push(8'h52, 2'd1, 1'b0, 3'd1);
    push(8'h53, 2'd1, 1'b1, 3'd3);
    push(8'h54, 2'd2, 1'b0, 3'd1);
    look("R5 first half in slot 3", 4, 32'h53525150, 4'b0000, 1'b1);
    look("R5 second half leads next group", 1, 32'h00000053, 4'b0001, 1'b1);
    look("R2 next iteration alone", 1, 32'h00000054, 4'b0000, 1'b1);
    look("R8 empty", 0, 32'h0, 4'b0000, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_restricted_body();
    t_unrestricted();
    t_split();
    t_carry();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule